// File: doc/BRIEF.md
# Configurable Triple-Mode Segment Decoder

This block turns one digit's worth of display data into the eight anode enables of a multiplexed common-cathode LED display. The scan logic around it presents the index of the bank being lit, and the block picks that bank's nibble out of a packed display word. It then decodes the nibble in the mode that the configuration byte gives that bank. Each bank can use one of three modes: a hexadecimal seven-segment glyph, a glyph from a sixteen-entry letter and symbol table, or raw lamp control. In raw mode the low four nibble bits drive four anodes directly.

The decimal-point anode does not come from the nibble. It comes from a shared 3-bit code that names which banks show their point. That code works the same way in every mode. All eight outputs leave through one register, so they move on the same clock edge as the scan logic's own registered bank select.

Top module: `segdec_top`

## Requirements
- R1: While `rstN` is low, `segOut` is 8'h00.
- R2: `segOut` updates only on a rising clock edge. It reflects the inputs sampled at that edge, and an input change between edges leaves it unchanged.
- R3: In hex mode, `segOut[6:0]` (bit 0 = a through bit 6 = g) carries the glyph for values 0..F: 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71.
- R4: The mode of bank k (k = 0..4) is chosen as follows. If `cfgBits[k+1]` is 0, the bank is in hex mode. Otherwise a group bit decides: `cfgBits[6]` for banks 0..2 and `cfgBits[7]` for banks 3..4. A group bit of 1 selects special mode and 0 selects raw mode.
- R5: In raw mode, `segOut[3:0]` equals nibble bits 3:0 and `segOut[6:4]` is 0.
- R6: In special mode, `segOut[6:0]` for values 0..F is 00,58,76,74,1E,38,54,5C,73,50,3E,1C,6E,40,48,63.
- R7: `segOut[7]` (h) follows `pointCode` as follows. Codes 1..5 light only bank code-1. Code 6 lights banks 0 and 1. Code 7 lights every bank. Code 0 lights none.
- R8: The h output does not depend on the bank's decode mode.
- R9: `bankSel` values 0..4 select the nibble at `dispNibbles[4k+3:4k]`. Values 5..7 give `segOut` = 8'h00, including h.
- R10: `cfgBits[0]` has no effect on `segOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bankSel | input | 3 | Index of the bank being scanned |
| dispNibbles | input | 20 | Five packed 4-bit digit values, bank 0 in the low bits |
| pointCode | input | 3 | Decimal-point bank code |
| cfgBits | input | 8 | Per-bank mode bits [5:1], group bits [7:6], bit 0 unused |
| segOut | output | 8 | Anode enables, bit 0 = a … bit 6 = g, bit 7 = h |

## Verification
A wrong mode decision appears as a wrong glyph on the very next edge for that bank. A wrong group-bit split only shows when the scan reaches bank 2 or bank 3 with the two group bits set differently. An error in the point mask can hide behind codes that light several banks, so every code is paired with every bank index. An out-of-range select that leaks the last valid bank's data shows as a non-zero output one edge after the select rises above 4.

// File: rtl/segdec_pkg.sv
package segdec_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {
    MODE_HEX     = 2'd0,
    MODE_SPECIAL = 2'd1,
    MODE_RAW     = 2'd2
  } decMode_t;

  typedef struct packed {
    logic             valid;
    decMode_t         mode;
    logic [NIB_W-1:0] nib;
    logic             pointOn;
  } decStrobe_t;

  function automatic logic [6:0] hexGlyph(input logic [NIB_W-1:0] v);
    case (v)
      4'h0: hexGlyph = 7'h3F;
      4'h1: hexGlyph = 7'h06;
      4'h2: hexGlyph = 7'h5B;
      4'h3: hexGlyph = 7'h4F;
      4'h4: hexGlyph = 7'h66;
      4'h5: hexGlyph = 7'h6D;
      4'h6: hexGlyph = 7'h7D;
      4'h7: hexGlyph = 7'h07;
      4'h8: hexGlyph = 7'h7F;
      4'h9: hexGlyph = 7'h6F;
      4'hA: hexGlyph = 7'h77;
      4'hB: hexGlyph = 7'h7C;
      4'hC: hexGlyph = 7'h39;
      4'hD: hexGlyph = 7'h5E;
      4'hE: hexGlyph = 7'h79;
      default: hexGlyph = 7'h71;
    endcase
  endfunction
endpackage

// File: rtl/segdec_ctrl.sv
module segdec_ctrl
  import segdec_pkg::*;
#(
  parameter int NUM_BANKS   = 5,
  parameter int GROUP_SPLIT = 3,
  parameter int SEL_W       = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [SEL_W-1:0]           bankSel,
  input  logic [NUM_BANKS*NIB_W-1:0] dispNibbles,
  input  logic [2:0]                 pointCode,
  input  logic [7:0]                 cfgBits,
  output decStrobe_t                 strobe
);
  decMode_t             bankMode [NUM_BANKS];
  logic [NUM_BANKS-1:0] hMaskAll;

  // per-bank mode: own bit first, then the bank's group bit
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_mode
    localparam int GRP_BIT = (b < GROUP_SPLIT) ? 6 : 7;
    always_comb begin
      if (!cfgBits[b+1])        bankMode[b] = MODE_HEX;
      else if (cfgBits[GRP_BIT]) bankMode[b] = MODE_SPECIAL;
      else                       bankMode[b] = MODE_RAW;
    end
  end

  always_comb begin
    hMaskAll = '0;
    case (pointCode)
      3'd0: hMaskAll = '0;
      3'd6: hMaskAll[1:0] = 2'b11;
      3'd7: hMaskAll = '1;
      default: begin
        for (int b = 0; b < NUM_BANKS; b++)
          if (int'(pointCode) == b + 1) hMaskAll[b] = 1'b1;
      end
    endcase
  end

  always_comb begin
    strobe = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bankSel == SEL_W'(b)) begin
        strobe.valid   = 1'b1;
        strobe.mode    = bankMode[b];
        strobe.nib     = dispNibbles[b*NIB_W +: NIB_W];
        strobe.pointOn = hMaskAll[b];
      end
    end
  end

  p_point_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pointCode >= 3'd1 && pointCode <= 3'd5) |-> $countones(hMaskAll) == 1);
  p_point_all_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pointCode == 3'd7) |-> (&hMaskAll));
endmodule

// File: rtl/segdec_dp.sv
module segdec_dp
  import segdec_pkg::*;
#(
  parameter logic [15:0][6:0] SPECIAL_GLYPHS = '0
) (
  input  logic       clk,
  input  logic       rstN,
  input  decStrobe_t strobe,
  output logic [7:0] segOut
);
  logic [6:0] glyph;

  always_comb begin
    glyph = '0;
    if (strobe.valid) begin
      case (strobe.mode)
        MODE_HEX:     glyph = hexGlyph(strobe.nib);
        MODE_SPECIAL: glyph = SPECIAL_GLYPHS[strobe.nib];
        default:      glyph = {3'b000, strobe.nib};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) segOut <= '0;
    else       segOut <= {strobe.valid & strobe.pointOn, glyph};
  end

  p_raw_efg_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.valid && strobe.mode == MODE_RAW) |=> segOut[6:4] == 3'b000);
  p_raw_direct_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.valid && strobe.mode == MODE_RAW) |=> segOut[3:0] == $past(strobe.nib));
  p_invalid_blank_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.valid |=> segOut == 8'h00);
  p_point_follow_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.valid |=> segOut[7] == $past(strobe.pointOn));
endmodule

// File: rtl/segdec_top.sv
module segdec_top
  import segdec_pkg::*;
#(
  parameter int NUM_BANKS   = 5,
  parameter int GROUP_SPLIT = 3,
  parameter logic [15:0][6:0] SPECIAL_GLYPHS = {
    7'h63, 7'h48, 7'h40, 7'h6E, 7'h1C, 7'h3E, 7'h50, 7'h73,
    7'h5C, 7'h54, 7'h38, 7'h1E, 7'h74, 7'h76, 7'h58, 7'h00},
  localparam int SEL_W  = 3,
  localparam int DISP_W = NUM_BANKS * NIB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SEL_W-1:0]  bankSel,
  input  logic [DISP_W-1:0] dispNibbles,
  input  logic [2:0]        pointCode,
  input  logic [7:0]        cfgBits,
  output logic [7:0]        segOut
);
  decStrobe_t strobe;

  segdec_ctrl #(
    .NUM_BANKS(NUM_BANKS), .GROUP_SPLIT(GROUP_SPLIT), .SEL_W(SEL_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .bankSel(bankSel), .dispNibbles(dispNibbles),
    .pointCode(pointCode), .cfgBits(cfgBits), .strobe(strobe)
  );

  segdec_dp #(.SPECIAL_GLYPHS(SPECIAL_GLYPHS)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .segOut(segOut)
  );
endmodule

// File: tb/test_segdec_top.sv
`timescale 1ns/1ps
module test_segdec_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  bankSel = '0;
  logic [19:0] dispNibbles = '0;
  logic [2:0]  pointCode = '0;
  logic [7:0]  cfgBits = '0;
  logic [7:0]  segOut;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  segdec_top i_segdec_top (
    .clk(clk), .rstN(rstN), .bankSel(bankSel), .dispNibbles(dispNibbles),
    .pointCode(pointCode), .cfgBits(cfgBits), .segOut(segOut)
  );

  function automatic logic [6:0] hexRef(input logic [3:0] v);
    logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                           7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return t[v];
  endfunction

  function automatic logic [6:0] specRef(input logic [3:0] v);
    logic [6:0] t [16] = '{7'h00, 7'h58, 7'h76, 7'h74, 7'h1E, 7'h38, 7'h54, 7'h5C,
                           7'h73, 7'h50, 7'h3E, 7'h1C, 7'h6E, 7'h40, 7'h48, 7'h63};
    return t[v];
  endfunction

  // 0 = hex, 1 = special, 2 = raw
  function automatic int modeRef(input int k, input logic [7:0] c);
    if (!c[k+1]) return 0;
    return (k < 3 ? c[6] : c[7]) ? 1 : 2;
  endfunction

  function automatic logic [7:0] expSeg(input logic [2:0] s, input logic [19:0] d,
                                        input logic [2:0] p, input logic [7:0] c);
    int k = int'(s);
    logic [3:0] n;
    logic h;
    logic [6:0] g;
    if (k > 4) return 8'h00;
    n = d[k*4 +: 4];
    case (modeRef(k, c))
      0: g = hexRef(n);
      1: g = specRef(n);
      default: g = {3'b000, n};
    endcase
    if (p == 3'd0) h = 1'b0;
    else if (p <= 3'd5) h = (k == int'(p) - 1);
    else if (p == 3'd6) h = (k < 2);
    else h = 1'b1;
    return {h, g};
  endfunction

  function automatic string tagFor(input logic [2:0] s, input logic [7:0] c);
    if (s > 3'd4) return "R9";
    case (modeRef(int'(s), c))
      0: return "R3";
      1: return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: segOut=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge after the output register loads
  task automatic apply(input logic [2:0] s, input logic [19:0] d,
                       input logic [2:0] p, input logic [7:0] c, input string tag);
    logic [7:0] e;
    bankSel = s; dispNibbles = d; pointCode = p; cfgBits = c;
    e = expSeg(s, d, p, c);
    @(negedge clk);
    check(tag, segOut[6:0] === e[6:0] ? segOut : segOut, e);
    checks++;
    if (segOut[7] !== e[7]) begin
      errors++;
      $display("FAIL R7: h=%b expected=%b", segOut[7], e[7]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] eA;
    void'($urandom(32'd1234));
    // R1: reset with busy inputs
    bankSel = 3'd0; dispNibbles = 20'h88888; pointCode = 3'd7; cfgBits = 8'hFF;
    repeat (3) @(negedge clk);
    check("R1", segOut, 8'h00);
    rstN = 1'b1;

    // R3 all hex values on bank 0
    for (int v = 0; v < 16; v++) apply(3'd0, 20'(v), 3'd0, 8'h00, "R3");
    // R6 all special values on bank 4
    for (int v = 0; v < 16; v++) apply(3'd4, 20'(v) << 16, 3'd0, 8'hA0, "R6");
    // R5 raw values on bank 2
    for (int v = 0; v < 16; v++) apply(3'd2, 20'(v) << 8, 3'd0, 8'h08, "R5");

    // R4: group bits differing, scan all banks
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < 5; k++)
        apply(3'(k), 20'h9A5C3, 3'd0, (c == 0) ? 8'h7E : (c == 1) ? 8'hBE :
              (c == 2) ? 8'hFE : 8'h3E, "R4");

    // R7/R8: every point code against every bank, in each mode
    for (int m = 0; m < 3; m++)
      for (int p = 0; p < 8; p++)
        for (int k = 0; k < 5; k++)
          apply(3'(k), 20'h12345, 3'(p), (m == 0) ? 8'h00 : (m == 1) ? 8'hFE : 8'h3E, "R8");

    // R9: out-of-range select, with all points lit
    for (int s = 5; s < 8; s++) apply(3'(s), 20'hFFFFF, 3'd7, 8'h00, "R9");

    // R10: bit 0 of configuration toggled, same result
    for (int k = 0; k < 5; k++) begin
      apply(3'(k), 20'h6B2E7, 3'd6, 8'h4A, "R10");
      apply(3'(k), 20'h6B2E7, 3'd6, 8'h4B, "R10");
    end

    // R2: change inputs between edges, output holds until the edge
    apply(3'd1, 20'h000D0, 3'd2, 8'h00, "R2");
    eA = expSeg(3'd1, 20'h000D0, 3'd2, 8'h00);
    bankSel = 3'd3; dispNibbles = 20'h0F000; pointCode = 3'd0; cfgBits = 8'h10;
    #1;
    check("R2", segOut, eA);
    @(negedge clk);
    check("R2", segOut, expSeg(3'd3, 20'h0F000, 3'd0, 8'h10));

    // random mix
    for (int i = 0; i < 1500; i++) begin
      logic [2:0] s = 3'($urandom);
      logic [7:0] c = 8'($urandom);
      apply(s, 20'($urandom), 3'($urandom), c, tagFor(s, c));
    end

    // R1 again: reset mid-run clears the output
    rstN = 1'b0;
    @(negedge clk);
    check("R1", segOut, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule